// File: doc/BRIEF.md
# Digital Audio Noise Gate

This block mutes low-level background noise in a single channel of signed PCM audio. Each incoming sample updates a peak-following level estimate. That estimate is compared with a threshold chosen by a 3-bit level code and a boost bit. The level must stay at or below the threshold for a selectable hold time, measured in samples. Once that time has passed, the gate shuts and the gain falls in 1 dB steps to a -96 dB floor. A single sample above the threshold reopens the gate, and the gain then climbs back to unity at the same step rate.

The ramp is paced by `ramp_tick`, a strobe that the system derives from its sample clock, so the attack and release rates follow the sample rate. The hold time is fixed at elaboration by two parameters, the sample rate in hertz and the length of one hold unit in milliseconds. Without boost, threshold codes 6 and 7 have no level assigned, and with either code the gate is switched off completely.

Top module: `noise_gate`

## Requirements
- R1: With `thr_boost`=0, `thr_code` values 0..5 select thresholds of -64, -67, -70, -73, -76 and -82 dBFS. The threshold magnitude is round(2^(DW-1) * 10^(-dB/20)).
- R2: With `thr_boost`=1, `thr_code` values 0..7 select -34, -37, -40, -43, -46, -52, -58 and -64 dBFS, using the same magnitude rule as R1.
- R3: With `thr_boost`=0 and `thr_code` equal to 6 or 7, every valid sample is passed out unchanged. The attenuation is forced to 0 and the hold count is cleared.
- R4: Each valid sample updates the level as env = max(|x|, env - floor(env/2^DS)). The sample is loud when this new env is strictly greater than the threshold magnitude.
- R5: The gate shuts on the edge of the H-th consecutive non-loud valid sample. H = (hold_code+1) * UNIT_MS * FS_HZ / 1000, so codes 0..3 give 50, 100, 150 and 200 ms when UNIT_MS is 50.
- R6: A loud valid sample clears the hold count and opens the gate at that same edge.
- R7: On each `ramp_tick` the attenuation moves by STEP_DB: up toward FLOOR_DB (96) while the gate is shut, and down toward 0 while it is open, saturating at both ends. Without a tick it does not change.
- R8: The output is floor(x * g / 2^20), where g = round(2^20 * 10^(-(a mod 6)/20)) >> (a div 6) and a is the attenuation in dB. At a = 0 the output equals the input exactly.
- R9: `gated_valid` follows `smp_valid` one clock later. The output uses the attenuation held before that edge. `gated_data` holds its value while no sample is valid.
- R10: After reset, `gated_valid` and `gated_data` are 0, the gate is open, the attenuation is 0 and the level estimate is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | DW | Signed input sample |
| thr_code | input | 3 | Threshold level code |
| thr_boost | input | 1 | Adds 30 dB to the threshold table |
| hold_code | input | 2 | Hold-time selection |
| ramp_tick | input | 1 | Gain step strobe |
| gated_valid | output | 1 | Output sample strobe |
| gated_data | output | DW | Signed gated sample |

## Verification
Each threshold setting, with and without boost, is paired with every hold code. For each pairing the bench plays a square tone at 4/5 of the threshold magnitude, then one at 5/4 of it. The quiet tone shows whether the gate shuts on exactly the expected sample, and the loud tone shows whether the gain ramps back to unity rather than jumping. A tone at exactly the threshold magnitude, compared with one a single count above it, checks the strict comparison. A lone loud spike inside a quiet run restarts the hold count and brings the peak-follower decay into play. Sparse and absent ticks separate the ramp pacing from the hold decision, and the two unassigned codes are checked for exact pass-through even after the gate has already shut.

// File: rtl/ng_pkg.sv
package ng_pkg;

  // dB below full scale for a threshold selection; 0 marks an unassigned code
  function automatic int ng_thr_db(int code, int boost);
    int db;
    if (boost != 0) begin
      case (code)
        0: db = 34;
        1: db = 37;
        2: db = 40;
        3: db = 43;
        4: db = 46;
        5: db = 52;
        6: db = 58;
        default: db = 64;
      endcase
    end else begin
      case (code)
        0: db = 64;
        1: db = 67;
        2: db = 70;
        3: db = 73;
        4: db = 76;
        5: db = 82;
        default: db = 0;
      endcase
    end
    return db;
  endfunction

  // linear magnitude of a level db below full scale of a bits-wide signed sample
  function automatic int ng_db_to_mag(int bits, int db);
    real fs;
    real m;
    fs = 2.0 ** (bits - 1);
    m  = fs * (10.0 ** (-real'(db) / 20.0));
    return $rtoi(m + 0.5);
  endfunction

  // fractional part of the gain law: one of six sub-6dB steps in Q(gf)
  function automatic int ng_gain_frac(int gf, int r);
    real m;
    m = (2.0 ** gf) * (10.0 ** (-real'(r) / 20.0));
    return $rtoi(m + 0.5);
  endfunction

  // hold length in samples for a delay code
  function automatic int ng_hold_samples(int code, int fs_hz, int unit_ms);
    return ((code + 1) * unit_ms * fs_hz) / 1000;
  endfunction

endpackage

// File: rtl/ng_level_det.sv
module ng_level_det #(
  parameter int DW = 16,
  parameter int DS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic        [DW-1:0] thr_mag,
  output logic        [DW-1:0] env_q,
  output logic                 loud
);

  logic [DW-1:0] mag;
  logic [DW-1:0] decayed;
  logic [DW-1:0] env_next;

  always_comb begin
    mag      = in_data[DW-1] ? DW'(-in_data) : DW'(in_data);
    decayed  = env_q - (env_q >> DS);
    env_next = (mag > decayed) ? mag : decayed;
    loud     = env_next > thr_mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        env_q <= '0;
    else if (in_valid) env_q <= env_next;
  end

endmodule

// File: rtl/ng_hold_ctrl.sv
module ng_hold_ctrl #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          loud,
  input  logic          gate_off,
  input  logic [CW-1:0] hold_len,
  output logic          closed,
  output logic [CW-1:0] hold_cnt
);

  logic [CW:0] cnt_inc;
  logic        reach;

  always_comb begin
    cnt_inc = {1'b0, hold_cnt} + (CW+1)'(1);
    reach   = cnt_inc >= {1'b0, hold_len};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      closed   <= 1'b0;
    end else if (gate_off) begin
      hold_cnt <= '0;
      closed   <= 1'b0;
    end else if (in_valid) begin
      if (loud) begin
        hold_cnt <= '0;
        closed   <= 1'b0;
      end else begin
        closed <= reach;
        if (hold_cnt < hold_len) hold_cnt <= cnt_inc[CW-1:0];
      end
    end
  end

endmodule

// File: rtl/ng_gain_ramp.sv
module ng_gain_ramp #(
  parameter int AW       = 7,
  parameter int FLOOR_DB = 96,
  parameter int STEP_DB  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          closed,
  input  logic          gate_off,
  output logic [AW-1:0] att
);

  localparam logic [AW:0] FLOOR_W = (AW+1)'(FLOOR_DB);
  localparam logic [AW:0] STEP_W  = (AW+1)'(STEP_DB);

  logic [AW:0] up_sum;
  logic [AW:0] att_w;
  logic [AW:0] next_up;
  logic [AW:0] next_dn;

  always_comb begin
    att_w   = {1'b0, att};
    up_sum  = att_w + STEP_W;
    next_up = (up_sum > FLOOR_W) ? FLOOR_W : up_sum;
    next_dn = (att_w < STEP_W) ? '0 : (att_w - STEP_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        att <= '0;
    else if (gate_off) att <= '0;
    else if (tick)     att <= closed ? next_up[AW-1:0] : next_dn[AW-1:0];
  end

endmodule

// File: rtl/ng_gain_apply.sv
module ng_gain_apply #(
  parameter int DW = 16,
  parameter int GF = 20,
  parameter int AW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic        [AW-1:0] att,
  input  logic                 bypass,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  localparam int          PW  = DW + GF + 2;
  localparam logic [AW-1:0] SIX = AW'(6);

  logic [GF:0] frac_tab [6];

  for (genvar gr = 0; gr < 6; gr++) begin : g_frac
    localparam int FR = ng_pkg::ng_gain_frac(GF, gr);
    assign frac_tab[gr] = (GF+1)'(FR);
  end

  logic [2:0]           att_mod;
  logic [AW-1:0]        att_div;
  logic [GF:0]          gain;
  logic signed [PW-1:0] prod;
  logic signed [DW-1:0] scaled;

  always_comb begin
    att_mod = 3'(att % SIX);
    att_div = att / SIX;
    gain    = frac_tab[att_mod] >> att_div;
    prod    = PW'(in_data) * PW'($signed({1'b0, gain}));
    scaled  = DW'(prod >>> GF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= bypass ? in_data : scaled;
    end
  end

endmodule

// File: rtl/noise_gate.sv
module noise_gate #(
  parameter int DW       = 16,
  parameter int DS       = 4,
  parameter int FS_HZ    = 48000,
  parameter int UNIT_MS  = 50,
  parameter int FLOOR_DB = 96,
  parameter int STEP_DB  = 1,
  parameter int GF       = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  input  logic [2:0]           thr_code,
  input  logic                 thr_boost,
  input  logic [1:0]           hold_code,
  input  logic                 ramp_tick,
  output logic                 gated_valid,
  output logic signed [DW-1:0] gated_data
);

  localparam int MAX_HOLD = ng_pkg::ng_hold_samples(3, FS_HZ, UNIT_MS);
  localparam int CW       = $clog2(MAX_HOLD + 1);
  localparam int AW       = $clog2(FLOOR_DB + 1);

  // threshold magnitudes, indexed by {boost, code}
  logic [DW-1:0] thr_tab [16];
  for (genvar gi = 0; gi < 16; gi++) begin : g_thr
    localparam int DB  = ng_pkg::ng_thr_db(gi % 8, gi / 8);
    localparam int MAG = (DB == 0) ? 0 : ng_pkg::ng_db_to_mag(DW, DB);
    assign thr_tab[gi] = DW'(MAG);
  end

  // hold lengths in samples, indexed by delay code
  logic [CW-1:0] hold_tab [4];
  for (genvar gh = 0; gh < 4; gh++) begin : g_hold
    localparam int HS = ng_pkg::ng_hold_samples(gh, FS_HZ, UNIT_MS);
    assign hold_tab[gh] = CW'(HS);
  end

  // named internal events, visible to the bound checker
  logic [DW-1:0] thr_sel;
  logic [CW-1:0] hold_len;
  logic          gate_off;
  logic          loud_w;
  logic          closed_q;
  logic [CW-1:0] hold_cnt_q;
  logic [AW-1:0] att_q;
  logic [DW-1:0] env_q;

  always_comb begin
    thr_sel  = thr_tab[{thr_boost, thr_code}];
    hold_len = hold_tab[hold_code];
    gate_off = !thr_boost && thr_code[2] && thr_code[1];
  end

  ng_level_det #(.DW(DW), .DS(DS)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (smp_valid),
    .in_data  (smp_data),
    .thr_mag  (thr_sel),
    .env_q    (env_q),
    .loud     (loud_w)
  );

  ng_hold_ctrl #(.CW(CW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (smp_valid),
    .loud     (loud_w),
    .gate_off (gate_off),
    .hold_len (hold_len),
    .closed   (closed_q),
    .hold_cnt (hold_cnt_q)
  );

  ng_gain_ramp #(.AW(AW), .FLOOR_DB(FLOOR_DB), .STEP_DB(STEP_DB)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ramp_tick),
    .closed   (closed_q),
    .gate_off (gate_off),
    .att      (att_q)
  );

  ng_gain_apply #(.DW(DW), .GF(GF), .AW(AW)) u_apply (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (smp_valid),
    .in_data   (smp_data),
    .att       (att_q),
    .bypass    (gate_off),
    .out_valid (gated_valid),
    .out_data  (gated_data)
  );

endmodule

// File: rtl/ng_chk.sv
module ng_chk #(
  parameter int DW       = 16,
  parameter int AW       = 7,
  parameter int CW       = 14,
  parameter int FLOOR_DB = 96
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_data,
  input logic                 tick,
  input logic                 loud,
  input logic                 closed,
  input logic                 gate_off,
  input logic [AW-1:0]        att,
  input logic [CW-1:0]        hold_cnt,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data
);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && att == '0) |=> (out_data == $past(in_data)));

  // R3
  unassigned_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gate_off) |=> (out_data == $past(in_data)));

  // R3
  unassigned_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> (att == '0 && !closed && hold_cnt == '0));

  // R6
  loud_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && loud && !gate_off) |=> (!closed && hold_cnt == '0));

  // R5
  closed_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !gate_off) |=> $stable(closed));

  // R7
  att_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(att) <= FLOOR_DB);

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !gate_off) |=> (att == $past(att)));

  // R7
  attack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gate_off && closed && 32'(att) < FLOOR_DB) |=> (att > $past(att)));

endmodule

bind noise_gate ng_chk #(
  .DW(DW), .AW(AW), .CW(CW), .FLOOR_DB(FLOOR_DB)
) u_ng_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (smp_valid),
  .in_data   (smp_data),
  .tick      (ramp_tick),
  .loud      (loud_w),
  .closed    (closed_q),
  .gate_off  (gate_off),
  .att       (att_q),
  .hold_cnt  (hold_cnt_q),
  .out_valid (gated_valid),
  .out_data  (gated_data)
);

// File: tb/tb_noise_gate.sv
module tb_noise_gate;

  localparam int DW    = 20;
  localparam int DS    = 4;
  localparam int FS_HZ = 2000;
  localparam int UNIT  = 50;
  localparam int FLOOR = 96;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 smp_valid = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic [2:0]           thr_code = '0;
  logic                 thr_boost = 1'b0;
  logic [1:0]           hold_code = '0;
  logic                 ramp_tick = 1'b0;
  logic                 gated_valid;
  logic signed [DW-1:0] gated_data;

  always #5 clk = ~clk;

  noise_gate #(.DW(DW), .DS(DS), .FS_HZ(FS_HZ), .UNIT_MS(UNIT),
               .FLOOR_DB(FLOOR), .STEP_DB(1), .GF(20)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .thr_code(thr_code), .thr_boost(thr_boost), .hold_code(hold_code),
    .ramp_tick(ramp_tick), .gated_valid(gated_valid), .gated_data(gated_data)
  );

  int tests = 0;
  int fails = 0;

  // reference state, built from the requirement text
  longint env_m;
  int     cnt_m;
  bit     closed_m;
  int     att_m;
  longint last_in;
  longint last_out;

  function automatic int db_of(int code, int boost);
    int t_boost [8] = '{34, 37, 40, 43, 46, 52, 58, 64};
    int t_base  [8] = '{64, 67, 70, 73, 76, 82, 0, 0};
    return boost != 0 ? t_boost[code] : t_base[code];
  endfunction

  function automatic longint thr_b();
    int db = db_of(int'(thr_code), int'(thr_boost));
    return longint'($rtoi((2.0 ** (DW-1)) * (10.0 ** (-real'(db) / 20.0)) + 0.5));
  endfunction

  function automatic int hold_b();
    return (int'(hold_code) + 1) * UNIT * FS_HZ / 1000;
  endfunction

  function automatic longint apply_b(longint x, int a);
    longint g = longint'($rtoi((2.0 ** 20) * (10.0 ** (-real'(a % 6) / 20.0)) + 0.5)) >> (a / 6);
    return (x * g) >>> 20;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; ramp_tick = 1'b0; smp_data = '0;
    env_m = 0; cnt_m = 0; closed_m = 0; att_m = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one cycle at a falling edge, advance the model, check at the next falling edge
  task automatic step(input bit v, input longint x, input bit tk, input string tag);
    bit     off, loud, c_old;
    longint mag, dec, exp_d;
    off   = !thr_boost && thr_code >= 3'd6;
    c_old = closed_m;
    smp_valid = v; smp_data = DW'(x); ramp_tick = tk;
    exp_d = 0;
    loud  = 0;
    if (v) begin
      exp_d = off ? x : apply_b(x, att_m);
      mag = (x < 0) ? -x : x;
      dec = env_m - (env_m >>> DS);
      env_m = (mag > dec) ? mag : dec;
      loud = env_m > thr_b();
    end
    if (off) begin
      cnt_m = 0; closed_m = 0;
    end else if (v) begin
      if (loud) begin
        cnt_m = 0; closed_m = 0;
      end else begin
        closed_m = (cnt_m + 1 >= hold_b());
        if (cnt_m < hold_b()) cnt_m++;
      end
    end
    if (off) att_m = 0;
    else if (tk) att_m = c_old ? ((att_m + 1 > FLOOR) ? FLOOR : att_m + 1)
                               : ((att_m < 1) ? 0 : att_m - 1);
    @(negedge clk);
    check(tag, longint'(gated_valid), longint'(v));
    if (v) begin
      check(tag, longint'(gated_data), exp_d);
      last_in  = x;
      last_out = longint'(gated_data);
    end
  endtask

  // quiet tone then loud tone on one configuration
  task automatic run_gate(input int boost, input int code, input int dcode);
    longint thr, qa, la, x;
    int     first_att, hl, lim;
    string  tg;
    do_reset();
    thr_boost = boost[0]; thr_code = code[2:0]; hold_code = dcode[1:0];
    tg  = boost != 0 ? "R2" : "R1";
    thr = thr_b();
    hl  = hold_b();
    qa  = thr * 4 / 5;
    la  = thr * 5 / 4;
    lim = (1 << (DW-1)) - 1;
    if (la > lim) la = lim;
    first_att = -1;
    for (int i = 1; i <= hl + 110; i++) begin
      x = (i % 2 == 1) ? qa : -qa;
      step(1'b1, x, 1'b1, tg);
      if (first_att < 0 && last_out != x) first_att = i;
    end
    // R5: unity through the hold and one more sample, first step on sample H+2
    check("R5", longint'(first_att), longint'(hl + 2));
    // R7: first loud sample still at the floor gain, no jump to unity
    step(1'b1, la, 1'b1, "R7");
    check("R7", longint'(last_out), apply_b(la, FLOOR));
    for (int i = 2; i <= 100; i++) begin
      x = (i % 2 == 1) ? la : -la;
      step(1'b1, x, 1'b1, "R6");
    end
    // R6: back to unity after the release ramp
    check("R6", last_out, last_in);
  endtask

  initial begin
    int nz;
    do_reset();
    @(negedge clk);
    // R10: reset state
    check("R10", longint'(gated_valid), 0);
    check("R10", longint'(gated_data), 0);
    step(1'b1, 12345, 1'b0, "R10");
    check("R10", last_out, 12345);

    // sweep: every delay code against every assigned threshold
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 6; c++) run_gate(0, c, d);
      for (int c = 0; c < 8; c++) run_gate(1, c, d);
    end

    // R4: a tone exactly at the threshold is quiet and gets gated
    do_reset();
    thr_boost = 1'b0; thr_code = 3'd0; hold_code = 2'd0;
    nz = 0;
    for (int i = 0; i < 200; i++) begin
      step(1'b1, (i % 2 == 0) ? thr_b() : -thr_b(), 1'b1, "R4");
      if (last_out != last_in) nz++;
    end
    check("R4", longint'(nz > 0), 1);
    // R4: one count above the threshold is loud and never gated
    do_reset();
    nz = 0;
    for (int i = 0; i < 300; i++) begin
      step(1'b1, (i % 2 == 0) ? thr_b() + 1 : -(thr_b() + 1), 1'b1, "R4");
      if (last_out != last_in) nz++;
    end
    check("R4", longint'(nz), 0);

    // R6: a spike inside the hold restarts it; the peak follower then decays
    do_reset();
    thr_boost = 1'b1; thr_code = 3'd0; hold_code = 2'd0;
    for (int i = 0; i < 60; i++) step(1'b1, thr_b() / 2, 1'b1, "R6");
    step(1'b1, thr_b() * 3, 1'b1, "R6");
    for (int i = 0; i < 300; i++) step(1'b1, (i % 2 == 0) ? thr_b() / 2 : -(thr_b() / 2), 1'b1, "R6");

    // R7: sparse ticks, idle gaps and a stretch with no ticks at all
    do_reset();
    thr_boost = 1'b1; thr_code = 3'd2; hold_code = 2'd1;
    for (int i = 0; i < 600; i++) begin
      step(1'b1, (i % 2 == 0) ? thr_b() / 2 : -(thr_b() / 2), (i % 3 == 0), "R7");
      if (i % 7 == 0) step(1'b0, 0, 1'b0, "R9");
    end
    for (int i = 0; i < 50; i++) step(1'b1, thr_b() / 3, 1'b0, "R7");
    // R8: exact gain law through a release ramp with a large tone
    for (int i = 0; i < 200; i++) step(1'b1, (i % 2 == 0) ? 400000 : -400000, (i % 2 == 0), "R8");

    // R3: unassigned codes pass everything, even after the gate has shut
    do_reset();
    thr_boost = 1'b0; thr_code = 3'd0; hold_code = 2'd0;
    for (int i = 0; i < 150; i++) step(1'b1, 7, 1'b1, "R3");
    thr_code = 3'd6;
    for (int i = 0; i < 500; i++) step(1'b1, (i % 2 == 0) ? 5 : -5, 1'b1, "R3");
    check("R3", last_out, last_in);
    thr_code = 3'd7;
    for (int i = 0; i < 500; i++) step(1'b1, (i % 2 == 0) ? 3 : -3, (i % 2 == 0), "R3");
    check("R3", last_out, last_in);

    // R9: idle cycles give no output strobe
    for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b0, "R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R9: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule